// File: doc/BRIEF.md
# Watchdog Interval Timer with Reset Pulse

This block is a watchdog timer attached to a small register bus and clocked by the peripheral clock. A 16-bit down-counter advances once per tick. Each tick is derived from the clock through an 8-bit prescaler followed by a divider that divides by 16, 32, 64 or 128. When a tick finds the counter already at zero, the block records a timeout and reloads the counter from a reload register. A timeout can do either or both of two things. It can raise a single-cycle interrupt request, and it can start an internal reset pulse that lasts exactly 128 clocks. With reset disabled and the interrupt enabled, the block works as a periodic interval timer.

Turning the timer on does not copy the reload value into the counter. Software must therefore write a start value into the count register before it enables the timer. Software keeps the watchdog satisfied by rewriting the count register before it expires. A write to the control register or to the count register also restarts the prescaler and the divider. Writing zero to the control register stops the counting and blocks the reset.

The reset pulse is produced by a two-state machine. In state `RP_IDLE` the output is low. The transition `RP_IDLE -> RP_PULSE` is taken on a timeout while the reset enable is set. In state `RP_PULSE` the output is high and a cycle counter advances. The transition `RP_PULSE -> RP_IDLE` is taken when that counter reaches 127. Any timeout that arrives while the machine is in `RP_PULSE` is ignored.

Top module: `wdt_timer`

## Requirements
- R1: After reset, the control register reads 0x8039. This value means prescaler 0x80, timer enabled, division by 128, interrupt disabled and reset enabled. The reload and count registers both read 0x8000, and `irq_o` and `wdt_rst_o` are low.
- R2: The register addresses are 0 for control, 1 for reload and 2 for count. Reads are combinational. In the control register, bits 7, 6 and 1 always read 0. Address 3 reads 0.
- R3: The control fields are: bits [15:8] prescaler value PRE, bit 5 timer enable, bits [4:3] division select SEL, bit 2 interrupt enable and bit 0 reset enable. One tick spans (PRE+1)*(16<<SEL) clocks. Tick k falls on clock edge E + k*(PRE+1)*(16<<SEL), where E is the edge of the most recent write to the control or count register. Each tick that finds the counter nonzero lowers it by one.
- R4: A tick that finds the counter at zero is a timeout, and it loads the counter with the reload value. Consecutive timeouts are therefore (reload+1) ticks apart.
- R5: With the interrupt enable set, each timeout raises `irq_o` for exactly one cycle, starting at the timeout edge. If the count was written with N and the timer is enabled, `irq_o` first rises at edge E + (N+1)*tick period.
- R6: With the interrupt enable clear, a timeout does not raise `irq_o`.
- R7: With the reset enable set, a timeout raises `wdt_rst_o` at the timeout edge, and it stays high for exactly 128 clock cycles.
- R8: A timeout that occurs while the reset pulse is active neither restarts the pulse nor extends it. Such a timeout still produces its interrupt.
- R9: With the reset enable clear, timeouts never raise `wdt_rst_o`.
- R10: While the timer enable is clear, the counter holds its value and no timeout occurs. Writing 0 to the control register therefore stops all counting, interrupts and resets.
- R11: Setting the timer enable does not load the reload value into the counter. The counter keeps the value that was last written to it.
- R12: A write to the count register takes effect at the next clock edge and restarts the countdown. Rewriting the count register before it expires prevents any timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register (combinational) |
| irq_o | output | 1 | One-cycle interrupt request on timeout |
| wdt_rst_o | output | 1 | Internal reset pulse, 128 clocks long |

## Verification
On every cycle, assertions check the following properties. Each tick lowers the counter by one or reloads it. The counter holds its value when there is neither a tick nor a write. Ticks and interrupt pulses never last longer than one cycle. The reset machine stays in `RP_PULSE` until its count completes, ignores a timeout that arrives during the pulse, and leaves only after exactly 128 cycles. The bench scenarios cover what the assertions cannot see. These are the absolute timeout cycle across a sweep of prescaler, division and start-count settings, the reload period, the register reset values and the field masking, the effect of the two enable bits, and servicing by rewriting the count register.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_RELOAD = 2'd1;
    localparam logic [1:0] ADDR_COUNT  = 2'd2;

    localparam int unsigned CTRL_PRE_LSB = 8;
    localparam int unsigned CTRL_RUN     = 5;
    localparam int unsigned CTRL_SEL_LSB = 3;
    localparam int unsigned CTRL_IRQ     = 2;
    localparam int unsigned CTRL_RST     = 0;

    typedef enum logic {
        RP_IDLE  = 1'b0,
        RP_PULSE = 1'b1
    } rst_state_e;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int unsigned PRE_W         = 8,
    parameter int unsigned DIV_BASE_LOG2 = 4,
    localparam int unsigned SEL_N        = 4,
    localparam int unsigned DIV_W        = DIV_BASE_LOG2 + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] presc,
    input  logic [1:0]       div_sel,
    output logic             tick
);
    logic [PRE_W-1:0] pre_cnt_q;
    logic [DIV_W-1:0] div_cnt_q;
    logic [DIV_W-1:0] div_last;
    logic [DIV_W-1:0] last_tab [SEL_N];
    logic             pre_pulse;
    logic             active;

    for (genvar g = 0; g < SEL_N; g++) begin : g_last
        assign last_tab[g] = DIV_W'((1 << (DIV_BASE_LOG2 + g)) - 1);
    end

    assign div_last  = last_tab[div_sel];
    assign active    = run && !restart;
    assign pre_pulse = active && (pre_cnt_q == presc);
    assign tick      = pre_pulse && (div_cnt_q == div_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt_q <= '0;
        end else if (!active || pre_pulse) begin
            pre_cnt_q <= '0;
        end else begin
            pre_cnt_q <= pre_cnt_q + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt_q <= '0;
        end else if (!active) begin
            div_cnt_q <= '0;
        end else if (pre_pulse) begin
            div_cnt_q <= (div_cnt_q == div_last) ? '0 : div_cnt_q + DIV_W'(1);
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R3
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int unsigned CNT_W    = 16,
    parameter logic [CNT_W-1:0] CNT_INIT = CNT_W'(16'h8000)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload,
    input  logic             irq_en,
    output logic [CNT_W-1:0] count,
    output logic             timeout,
    output logic             irq_o
);
    logic [CNT_W-1:0] count_q;
    logic             irq_q;

    assign timeout = tick && !load && (count_q == '0);
    assign count   = count_q;
    assign irq_o   = irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= CNT_INIT;
        end else if (load) begin
            count_q <= load_val;
        end else if (tick) begin
            count_q <= (count_q == '0) ? reload : count_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= timeout && irq_en;
        end
    end

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && count_q != '0) |=> count_q == $past(count_q) - CNT_W'(1)); // R3
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> count_q == $past(reload)); // R4
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(count_q)); // R10
endmodule

// File: rtl/wdt_rst_fsm.sv
module wdt_rst_fsm
    import wdt_pkg::*;
#(
    parameter int unsigned RST_CYCLES = 128,
    localparam int unsigned PC_W      = $clog2(RST_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic rst_o
);
    localparam logic [PC_W-1:0] LAST = PC_W'(RST_CYCLES - 1);

    rst_state_e      state_q, state_d;
    logic [PC_W-1:0] pcnt_q, pcnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RP_IDLE;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            pcnt_q  <= pcnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        pcnt_d  = pcnt_q;
        unique case (state_q)
            RP_IDLE: begin
                pcnt_d = '0;
                if (trigger) begin
                    state_d = RP_PULSE;
                end
            end
            RP_PULSE: begin
                if (pcnt_q == LAST) begin
                    state_d = RP_IDLE;
                    pcnt_d  = '0;
                end else begin
                    pcnt_d = pcnt_q + PC_W'(1);
                end
            end
            default: begin
                state_d = RP_IDLE;
                pcnt_d  = '0;
            end
        endcase
    end

    always_comb begin
        rst_o = (state_q == RP_PULSE);
    end

    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RP_PULSE && pcnt_q != LAST) |=> rst_o); // R7
    AST_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_o) |-> $past(pcnt_q) == LAST); // R7
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RP_PULSE && trigger && pcnt_q != LAST) |=> pcnt_q == $past(pcnt_q) + PC_W'(1)); // R8
    AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_o) |-> pcnt_q == '0); // R7
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W         = 16,
    parameter int unsigned PRE_W         = 8,
    parameter int unsigned DIV_BASE_LOG2 = 4,
    parameter int unsigned RST_CYCLES    = 128,
    parameter logic [CNT_W-1:0] CNT_INIT = CNT_W'(16'h8000),
    parameter logic [PRE_W-1:0] PRE_INIT = PRE_W'(8'h80),
    parameter logic [1:0]       SEL_INIT = 2'd3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq_o,
    output logic             wdt_rst_o
);
    logic [PRE_W-1:0] presc_q;
    logic             run_q;
    logic [1:0]       sel_q;
    logic             irq_en_q;
    logic             rst_en_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] ctrl_img;
    logic             ctrl_wr, reload_wr, count_wr, restart;
    logic             tick, timeout;
    logic             wdata_unused;

    assign ctrl_wr      = bus_wr && (bus_addr == ADDR_CTRL);
    assign reload_wr    = bus_wr && (bus_addr == ADDR_RELOAD);
    assign count_wr     = bus_wr && (bus_addr == ADDR_COUNT);
    assign restart      = ctrl_wr || count_wr;
    assign wdata_unused = ^{bus_wdata[7:6], bus_wdata[1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q  <= PRE_INIT;
            run_q    <= 1'b1;
            sel_q    <= SEL_INIT;
            irq_en_q <= 1'b0;
            rst_en_q <= 1'b1;
        end else if (ctrl_wr) begin
            presc_q  <= bus_wdata[CTRL_PRE_LSB +: PRE_W];
            run_q    <= bus_wdata[CTRL_RUN];
            sel_q    <= bus_wdata[CTRL_SEL_LSB +: 2];
            irq_en_q <= bus_wdata[CTRL_IRQ];
            rst_en_q <= bus_wdata[CTRL_RST];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= CNT_INIT;
        end else if (reload_wr) begin
            reload_q <= bus_wdata;
        end
    end

    always_comb begin
        ctrl_img = '0;
        ctrl_img[CTRL_PRE_LSB +: PRE_W] = presc_q;
        ctrl_img[CTRL_RUN]              = run_q;
        ctrl_img[CTRL_SEL_LSB +: 2]     = sel_q;
        ctrl_img[CTRL_IRQ]              = irq_en_q;
        ctrl_img[CTRL_RST]              = rst_en_q;
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL:   bus_rdata = ctrl_img;
            ADDR_RELOAD: bus_rdata = reload_q;
            ADDR_COUNT:  bus_rdata = count;
            default:     bus_rdata = '0;
        endcase
    end

    wdt_prescale #(
        .PRE_W        (PRE_W),
        .DIV_BASE_LOG2(DIV_BASE_LOG2)
    ) u_prescale (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_q),
        .restart(restart),
        .presc  (presc_q),
        .div_sel(sel_q),
        .tick   (tick)
    );

    wdt_counter #(
        .CNT_W   (CNT_W),
        .CNT_INIT(CNT_INIT)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .load    (count_wr),
        .load_val(bus_wdata),
        .reload  (reload_q),
        .irq_en  (irq_en_q),
        .count   (count),
        .timeout (timeout),
        .irq_o   (irq_o)
    );

    wdt_rst_fsm #(
        .RST_CYCLES(RST_CYCLES)
    ) u_rst_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .trigger(timeout && rst_en_q),
        .rst_o  (wdt_rst_o)
    );

    AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !count_wr) |=> $stable(count)); // R10
    AST_NO_RST_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_en_q && !wdt_rst_o) |=> !wdt_rst_o); // R9
    AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_q |=> !irq_o); // R6
endmodule

// File: tb/tb_wdt_timer.sv
module tb_wdt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd2;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_o;
    logic        wdt_rst_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    wdt_timer dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_o    (irq_o),
        .wdt_rst_o(wdt_rst_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wr    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_addr  = 2'd2;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
        bus_addr = 2'd2;
    endtask

    function automatic logic [15:0] ctrl_word(input int pre, input bit run, input int sel,
                                               input bit ien, input bit ren);
        return 16'((pre << 8) | (int'(run) << 5) | (sel << 3) | (int'(ien) << 2) | int'(ren));
    endfunction

    // Waits until irq_o is seen high, or lim cycles; returns cycles after the write edge
    task automatic wait_irq(input int lim, output int k, output bit rst_seen);
        k = 0;
        rst_seen = 1'b0;
        while (!irq_o && k < lim) begin
            @(negedge clk);
            k++;
            if (wdt_rst_o) rst_seen = 1'b1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int k;
        int per;
        bit rs;
        int rise, fall;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(0, v); check(v == 16'h8039, "R1 ctrl", v, 16'h8039);
        bus_read(1, v); check(v == 16'h8000, "R1 reload", v, 16'h8000);
        bus_read(2, v); check(v == 16'h8000, "R1 count", v, 16'h8000);
        check(!irq_o && !wdt_rst_o, "R1 outputs", {irq_o, wdt_rst_o}, 0);

        // R2 register access and masking
        bus_write(0, 16'hFFFF);
        bus_read(0, v); check(v == 16'hFF3D, "R2 ctrl mask", v, 16'hFF3D);
        bus_write(0, 16'h0000);
        bus_read(0, v); check(v == 16'h0000, "R2 ctrl off", v, 0);
        bus_write(1, 16'hBEEF);
        bus_read(1, v); check(v == 16'hBEEF, "R2 reload", v, 16'hBEEF);
        bus_read(3, v); check(v == 16'h0000, "R2 addr3", v, 0);

        // R3 R4 R5 R9 sweep of prescaler, division and start count
        for (int sel = 0; sel < 4; sel++) begin
            for (int pre = 0; pre < 3; pre++) begin
                for (int n = 0; n < 4; n++) begin
                    per = (pre + 1) * (16 << sel);
                    bus_write(0, 16'h0000);
                    bus_write(1, 16'(n + 1));
                    bus_write(2, 16'(n));
                    bus_write(0, ctrl_word(pre, 1'b1, sel, 1'b1, 1'b0));
                    wait_irq(per * (n + 1) + 20, k, rs);
                    check(irq_o && k == per * (n + 1), "R3 R5 timeout cycle", k, per * (n + 1));
                    check(!rs && !wdt_rst_o, "R9 no reset", int'(rs), 0);
                    bus_read(2, v); check(v == 16'(n + 1), "R4 reload on timeout", v, n + 1);
                    @(negedge clk);
                    check(!irq_o, "R5 single cycle irq", irq_o, 0);
                end
            end
        end

        // R3 decrement step and R11 enable does not load reload
        bus_write(0, 16'h0000);
        bus_write(1, 16'h1234);
        bus_write(2, 16'd7);
        bus_write(0, ctrl_word(0, 1'b1, 0, 1'b1, 1'b0));
        bus_read(2, v); check(v == 16'd7, "R11 count kept", v, 7);
        repeat (15) @(negedge clk);
        bus_read(2, v); check(v == 16'd7, "R3 before first tick", v, 7);
        @(negedge clk);
        bus_read(2, v); check(v == 16'd6, "R3 after first tick", v, 6);

        // R4 periodic timeouts, reload 2 -> 48 cycles apart
        bus_write(0, 16'h0000);
        bus_write(1, 16'd2);
        bus_write(2, 16'd0);
        bus_write(0, ctrl_word(0, 1'b1, 0, 1'b1, 1'b0));
        wait_irq(40, k, rs);
        check(irq_o && k == 16, "R4 first timeout", k, 16);
        @(negedge clk);
        wait_irq(60, k, rs);
        check(irq_o && k + 1 == 48, "R4 period", k + 1, 48);

        // R7 R8 reset pulse length and no retrigger
        bus_write(0, 16'h0000);
        bus_write(1, 16'd2);
        bus_write(2, 16'd0);
        bus_write(0, ctrl_word(0, 1'b1, 0, 1'b1, 1'b1));
        rise = -1; fall = -1;
        for (int c = 1; c <= 150; c++) begin
            @(negedge clk);
            if (wdt_rst_o && rise < 0) rise = c;
            if (!wdt_rst_o && rise >= 0 && fall < 0) fall = c;
            if (c == 64) check(irq_o && wdt_rst_o, "R8 timeout during pulse", {irq_o, wdt_rst_o}, 3);
        end
        check(rise == 16, "R7 pulse start", rise, 16);
        check(fall - rise == 128, "R7 R8 pulse length", fall - rise, 128);

        // R6 interrupt disabled, reset still fires
        bus_write(0, 16'h0000);
        repeat (130) @(negedge clk);
        bus_write(2, 16'd0);
        bus_write(0, ctrl_word(0, 1'b1, 0, 1'b0, 1'b1));
        wait_irq(100, k, rs);
        check(!irq_o, "R6 no irq", irq_o, 0);
        check(rs, "R6 reset still fires", int'(rs), 1);

        // R10 timer disabled holds count
        bus_write(0, 16'h0000);
        repeat (130) @(negedge clk);
        bus_write(2, 16'd5);
        bus_write(0, ctrl_word(0, 1'b0, 0, 1'b1, 1'b1));
        wait_irq(300, k, rs);
        check(!irq_o && !rs, "R10 disabled quiet", {irq_o, rs}, 0);
        bus_read(2, v); check(v == 16'd5, "R10 count held", v, 5);
        bus_write(2, 16'd0);
        bus_write(0, 16'h0000);
        wait_irq(300, k, rs);
        check(!irq_o && !rs, "R10 ctrl zero quiet", {irq_o, rs}, 0);
        bus_read(2, v); check(v == 16'd0, "R10 count held at zero", v, 0);

        // R12 servicing by rewriting count
        bus_write(2, 16'd2);
        bus_write(0, ctrl_word(0, 1'b1, 0, 1'b1, 1'b1));
        rs = 1'b0;
        for (int s = 0; s < 5; s++) begin
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (irq_o || wdt_rst_o) rs = 1'b1;
            end
            bus_write(2, 16'd2);
        end
        check(!rs, "R12 serviced no timeout", int'(rs), 0);
        wait_irq(80, k, rs);
        check(irq_o && k == 48, "R12 timeout after last service", k, 48);
        bus_write(0, 16'h0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule